// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This unit carries out the prefixed bit-manipulation group of an 8-bit processor datapath on a single operand. It handles circular and through-carry rotates in both directions, arithmetic and logical shifts, nibble swap, and the test, clear and set of one chosen bit. It also handles the four short accumulator rotate forms, which share the rotate data rules but differ in how they set the zero flag.

Each cycle the unit takes an operation code, a 3-bit bit index, the operand and the incoming flags. One clock edge later it presents the result, the new flags and a write-back enable. For a memory operand the surrounding sequencer does one load, presents the byte here, and then stores the result only when the write-back enable is high. Prefix fetch and memory access belong to the sequencer.

Flags travel as a 4-bit vector {Z, N, H, C}: Z at bit 3, N at bit 2, H at bit 1, C at bit 0.

Top module: `bitop_unit`

## Requirements
- R1: While reset is low, result, flags_out and wb_en are all zero. After reset the outputs reflect the inputs sampled at the previous rising clock edge, so the latency is one cycle.
- R2: Code 0 rotates left circular: old bit 7 goes to bit 0 and to C. Code 1 rotates right circular: old bit 0 goes to bit 7 and to C.
- R3: Code 2 rotates left through carry: old C enters bit 0 and old bit 7 becomes C. Code 3 rotates right through carry: old C enters bit 7 and old bit 0 becomes C.
- R4: Code 4 shifts left and fills bit 0 with zero, with old bit 7 going to C. Code 5 shifts right, keeps bit 7, and sends old bit 0 to C. Code 7 shifts right, fills bit 7 with zero, and sends old bit 0 to C.
- R5: Code 6 exchanges the high and low nibbles and clears C.
- R6: For codes 0 to 7, N and H are cleared, Z is set exactly when the result is zero, and wb_en is 1.
- R7: Codes 11 (rotate left circular), 12 (rotate right circular), 13 (rotate left through carry) and 14 (rotate right through carry) follow the data and C rules of R2 and R3. They always clear Z, N and H and drive wb_en to 1.
- R8: Code 8 tests a bit. Z is set when the selected bit is 0, N is cleared, H is set and C keeps its input value. The result equals the operand and wb_en is 0.
- R9: Code 9 clears the selected bit and code 10 sets it. All other bits pass through unchanged, flags_out equals flags_in, and wb_en is 1.
- R10: Code 15 is unused. The result equals the operand, flags_out equals flags_in, and wb_en is 0.
- R11: The bit index selects operand bit bit_sel, with index 0 the least significant bit. For all codes other than 8, 9 and 10 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select (codes in R2 to R10) |
| bit_sel | input | 3 | Bit index for test, clear and set |
| operand | input | 8 | Data byte |
| flags_in | input | 4 | Incoming {Z,N,H,C} |
| result | output | 8 | Registered result byte |
| flags_out | output | 4 | Registered new {Z,N,H,C} |
| wb_en | output | 1 | Store the result back |

## Verification
Rotates are driven with a set bit 7 or bit 0 and with both values of the incoming carry. This separates the circular forms from the through-carry forms, because only the through-carry forms move the old C into the vacated bit. Shifts use 0x81 and 0xFF, so that sign keeping, zero fill and the carry source can all be told apart. Swap and rotates are also fed values whose results are zero, so that a computed Z can be distinguished from the Z that the accumulator forms force to zero. Bit test, clear and set are run at indices 0, 3 and 7 with mixed incoming flags, which shows the bit mapping, that C is held and that every flag passes through.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                op_code,
  input  logic [$clog2(DATA_W)-1:0] bit_sel,
  input  logic [DATA_W-1:0]         operand,
  input  logic [3:0]                flags_in,
  output logic [DATA_W-1:0]         result,
  output logic [3:0]                flags_out,
  output logic                      wb_en
);
  localparam int HALF = DATA_W / 2;
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  logic              cin;
  logic              msb;
  logic              lsb;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] nxt_res;
  logic [3:0]        nxt_flg;
  logic              nxt_wb;
  logic              new_c;

  assign cin  = flags_in[FC];
  assign msb  = operand[DATA_W-1];
  assign lsb  = operand[0];
  assign mask = {{(DATA_W-1){1'b0}}, 1'b1} << bit_sel;

  always_comb begin
    nxt_res = operand;
    nxt_flg = flags_in;
    nxt_wb  = 1'b1;
    new_c   = cin;
    case (op_code)
      4'd0, 4'd11: begin nxt_res = {operand[DATA_W-2:0], msb}; new_c = msb; end
      4'd1, 4'd12: begin nxt_res = {lsb, operand[DATA_W-1:1]}; new_c = lsb; end
      4'd2, 4'd13: begin nxt_res = {operand[DATA_W-2:0], cin}; new_c = msb; end
      4'd3, 4'd14: begin nxt_res = {cin, operand[DATA_W-1:1]}; new_c = lsb; end
      4'd4: begin nxt_res = {operand[DATA_W-2:0], 1'b0}; new_c = msb; end
      4'd5: begin nxt_res = {msb, operand[DATA_W-1:1]}; new_c = lsb; end
      4'd6: begin nxt_res = {operand[HALF-1:0], operand[DATA_W-1:HALF]}; new_c = 1'b0; end
      4'd7: begin nxt_res = {1'b0, operand[DATA_W-1:1]}; new_c = lsb; end
      4'd9:  nxt_res = operand & ~mask;
      4'd10: nxt_res = operand | mask;
      default: ;
    endcase

    if (op_code <= 4'd7) begin
      nxt_flg[FZ] = (nxt_res == '0);
      nxt_flg[FN] = 1'b0;
      nxt_flg[FH] = 1'b0;
      nxt_flg[FC] = new_c;
    end else if (op_code >= 4'd11 && op_code <= 4'd14) begin
      nxt_flg = 4'b0000;
      nxt_flg[FC] = new_c;
    end else if (op_code == 4'd8) begin
      nxt_flg[FZ] = ((operand & mask) == '0);
      nxt_flg[FN] = 1'b0;
      nxt_flg[FH] = 1'b1;
      nxt_wb      = 1'b0;
    end else if (op_code == 4'd15) begin
      nxt_wb = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      flags_out <= '0;
      wb_en     <= 1'b0;
    end else begin
      result    <= nxt_res;
      flags_out <= nxt_flg;
      wb_en     <= nxt_wb;
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [3:0]                op_code,
  input logic [$clog2(DATA_W)-1:0] bit_sel,
  input logic [DATA_W-1:0]         operand,
  input logic [3:0]                flags_in,
  input logic [DATA_W-1:0]         result,
  input logic [3:0]                flags_out,
  input logic                      wb_en
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (result == '0 && flags_out == '0 && !wb_en);
  end

  a_r6_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_code) <= 4'd7 |-> !flags_out[2] && !flags_out[1] && wb_en &&
    (flags_out[3] == (result == '0)));

  a_r7_acc_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_code) >= 4'd11 && $past(op_code) <= 4'd14 |-> flags_out[3:1] == 3'b000);

  a_r8_test_holds: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_code) == 4'd8 |-> !wb_en && result == $past(operand) &&
    flags_out[0] == $past(flags_in[0]) && flags_out[1] && !flags_out[2]);

  a_r9_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    live && ($past(op_code) == 4'd9 || $past(op_code) == 4'd10) |->
    flags_out == $past(flags_in) && wb_en);

  a_r9_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_code) == 4'd10 |-> result[$past(bit_sel)]);

  a_r9_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_code) == 4'd9 |-> !result[$past(bit_sel)]);

  a_r10_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(op_code) == 4'd15 |-> !wb_en && result == $past(operand) &&
    flags_out == $past(flags_in));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .bit_sel(bit_sel),
  .operand(operand), .flags_in(flags_in), .result(result),
  .flags_out(flags_out), .wb_en(wb_en)
);

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_code = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] operand = '0;
  logic [3:0] flags_in = '0;
  logic [7:0] result;
  logic [3:0] flags_out;
  logic       wb_en;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .bit_sel(bit_sel),
    .operand(operand), .flags_in(flags_in), .result(result),
    .flags_out(flags_out), .wb_en(wb_en)
  );

  task automatic check(input string req, input logic [7:0] er, input logic [3:0] ef, input logic ew);
    total++;
    if (result !== er || flags_out !== ef || wb_en !== ew) begin
      bad++;
      $display("FAIL %s: got res=%h flg=%b wb=%b, want res=%h flg=%b wb=%b",
               req, result, flags_out, wb_en, er, ef, ew);
    end
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic [2:0] b,
                     input logic [7:0] d, input logic [3:0] f,
                     input logic [7:0] er, input logic [3:0] ef, input logic ew);
    @(negedge clk);
    op_code = op; bit_sel = b; operand = d; flags_in = f;
    @(negedge clk);
    check(req, er, ef, ew);
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    check("R1", 8'h00, 4'b0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_circular;
    run("R2", 4'd0, 3'd0, 8'h85, 4'b0000, 8'h0B, 4'b0001, 1'b1);
    run("R2", 4'd1, 3'd0, 8'h01, 4'b0000, 8'h80, 4'b0001, 1'b1);
  endtask

  task automatic t_through;
    run("R3", 4'd2, 3'd0, 8'h01, 4'b0001, 8'h03, 4'b0000, 1'b1);
    run("R3", 4'd2, 3'd0, 8'h80, 4'b0000, 8'h00, 4'b1001, 1'b1);
    run("R3", 4'd3, 3'd0, 8'h02, 4'b0001, 8'h81, 4'b0000, 1'b1);
    run("R3", 4'd3, 3'd0, 8'h01, 4'b0000, 8'h00, 4'b1001, 1'b1);
  endtask

  task automatic t_shifts;
    run("R4", 4'd4, 3'd0, 8'hFF, 4'b0110, 8'hFE, 4'b0001, 1'b1);
    run("R4", 4'd5, 3'd0, 8'h81, 4'b0000, 8'hC0, 4'b0001, 1'b1);
    run("R4", 4'd7, 3'd0, 8'h81, 4'b0000, 8'h40, 4'b0001, 1'b1);
  endtask

  task automatic t_swap;
    run("R5", 4'd6, 3'd0, 8'hA5, 4'b0001, 8'h5A, 4'b0000, 1'b1);
    run("R6", 4'd6, 3'd0, 8'h00, 4'b0111, 8'h00, 4'b1000, 1'b1);
  endtask

  task automatic t_acc;
    run("R7", 4'd11, 3'd0, 8'h80, 4'b1000, 8'h01, 4'b0001, 1'b1);
    run("R7", 4'd14, 3'd0, 8'h01, 4'b0000, 8'h00, 4'b0001, 1'b1);
    run("R7", 4'd13, 3'd0, 8'h00, 4'b0000, 8'h00, 4'b0000, 1'b1);
    run("R7", 4'd12, 3'd0, 8'h00, 4'b1110, 8'h00, 4'b0000, 1'b1);
  endtask

  task automatic t_test;
    run("R8", 4'd8, 3'd7, 8'h7F, 4'b0001, 8'h7F, 4'b1011, 1'b0);
    run("R8", 4'd8, 3'd0, 8'h01, 4'b0100, 8'h01, 4'b0010, 1'b0);
  endtask

  task automatic t_setres;
    run("R9", 4'd9, 3'd3, 8'hFF, 4'b1111, 8'hF7, 4'b1111, 1'b1);
    run("R11", 4'd10, 3'd0, 8'h00, 4'b0000, 8'h01, 4'b0000, 1'b1);
    run("R11", 4'd10, 3'd7, 8'h00, 4'b0101, 8'h80, 4'b0101, 1'b1);
    run("R11", 4'd4, 3'd5, 8'h01, 4'b0000, 8'h02, 4'b0000, 1'b1);
  endtask

  task automatic t_unused;
    run("R10", 4'd15, 3'd2, 8'h3C, 4'b1010, 8'h3C, 4'b1010, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    bad++; total++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_circular();
    t_through();
    t_shifts();
    t_swap();
    t_acc();
    t_test();
    t_setres();
    t_unused();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule